// File: doc/BRIEF.md
# Bank-switching memory manager register file

This block holds the byte-wide control registers of a bank-switching memory manager that sits on an 8-bit CPU bus. It recognises two register windows: a twelve-slot window that is visible only while the I/O area is mapped in, and a five-byte mirror at the top of memory that is always visible. The mirror exposes the configuration byte and four shortcuts, and each shortcut copies a stored preset into the configuration byte. Writes are masked per register. Some bits in the mode readback come from live cartridge and display-sense pins. The high bytes of the two page pointers are staged and take effect only when the matching low byte is written.

Reads are combinational: `rdata` shows the selected register when the address hits a window and otherwise shows `bus_in` unchanged. A write is taken on the rising clock edge while `wr_en` is high. The bus uses a plain strobe with no valid/ready handshake, so there is no back-pressure: every strobed write is accepted in its cycle. Register values are exported as plain outputs for the address-translation logic. Two mode flags leave the block as registered control pins.

Top module: `mmu_bank_regs`

## Requirements
- R1: After reset every slot is 0x00 except the page-1 low byte (slot 9), which is 0x01. Both staging bits are 0, and `cpu_sel` and `fsdir` are 0.
- R2: While mode bit 6 (compatibility) is 1, every read returns `bus_in` and every write in either window is ignored. Only reset leaves this state.
- R3: The full window answers at 0xD500–0xD50B (slot = address − 0xD500) only while configuration bit 0 is 0. The mirror answers at 0xFF00–0xFF04 whatever configuration bit 0 is. Reads at any other address return `bus_in`.
- R4: A write to the configuration byte (slot 0, or mirror offset 0) stores bits 6:0 and clears bit 7. Reading it from either window returns the stored value with bit 7 set.
- R5: Writes to preset slots 1–4 are masked with 0x7F. Writes to the RAM-sharing slot 6 are masked with 0x4F.
- R6: A read of the mode slot (5) returns (stored | 0x06), with bit 4 ANDed with `cart_game`, bit 5 ANDed with `cart_exrom` and bit 7 ANDed with `width_sense`.
- R7: The version slot (11) always reads 0x20, whatever was written to it.
- R8: A write to a pointer high slot (8 for page 0, 10 for page 1) stores only data bit 0 in a staging bit and leaves the high slot unchanged. A later write to the matching low slot (7 or 9) stores the low byte and copies the staging bit into the high slot.
- R9: A write at mirror offsets 1–4 loads the configuration byte from preset slot 1–4, whatever the write data is.
- R10: `cpu_sel` follows mode bit 0 and `fsdir` follows mode bit 3. Each changes only on the clock edge that takes a mode write, and so is valid one cycle after the write strobe.
- R11: `cfg_o`, `mode_o` and `ramcfg_o` show the stored slots 0, 5 and 6. `page0_o` and `page1_o` show {high bit 0, low byte} of each page pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | CPU bus address |
| wr_en | input | 1 | Write strobe, taken on the rising edge |
| wdata | input | 8 | Write data |
| bus_in | input | 8 | Data already on the bus, returned when no register is selected |
| cart_game | input | 1 | Cartridge game line, masks mode readback bit 4 |
| cart_exrom | input | 1 | Cartridge expansion-ROM line, masks mode readback bit 5 |
| width_sense | input | 1 | Display-width sense key, masks mode readback bit 7 |
| rdata | output | 8 | Read data |
| cfg_o | output | 8 | Stored configuration byte |
| mode_o | output | 8 | Stored mode byte |
| ramcfg_o | output | 8 | Stored RAM-sharing byte |
| page0_o | output | 9 | Page-0 pointer {high bit, low byte} |
| page1_o | output | 9 | Page-1 pointer {high bit, low byte} |
| cpu_sel | output | 1 | Processor-select flag (mode bit 0), registered |
| fsdir | output | 1 | Fast-serial-direction flag (mode bit 3), registered |

## Verification
The bench builds the block with its default parameters: full window at 0xD500, mirror at 0xFF00, version byte 0x20. With these values the window-open and window-closed cases, all five mirror offsets and the unmapped addresses just past the window (0xD50C–0xD50F) can all be reached from the random address mix. The random writes also toggle the I/O-off bit, so long runs pass through both window states. Entry into compatibility mode is kept for the end of the run, because only reset leaves it.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  localparam int SLOT_W = 4;
  localparam int NSLOT  = 1 << SLOT_W;

  localparam logic [SLOT_W-1:0] SL_CFG   = 4'd0;
  localparam logic [SLOT_W-1:0] SL_PRE_LO = 4'd1;
  localparam logic [SLOT_W-1:0] SL_PRE_HI = 4'd4;
  localparam logic [SLOT_W-1:0] SL_MODE  = 4'd5;
  localparam logic [SLOT_W-1:0] SL_RAM   = 4'd6;
  localparam logic [SLOT_W-1:0] SL_P0L   = 4'd7;
  localparam logic [SLOT_W-1:0] SL_P0H   = 4'd8;
  localparam logic [SLOT_W-1:0] SL_P1L   = 4'd9;
  localparam logic [SLOT_W-1:0] SL_P1H   = 4'd10;
  localparam logic [SLOT_W-1:0] SL_VER   = 4'd11;

  localparam int CFG_IO_BIT      = 0;
  localparam int MODE_CPU_BIT    = 0;
  localparam int MODE_FSD_BIT    = 3;
  localparam int MODE_COMPAT_BIT = 6;
endpackage

// File: rtl/mmu_win_decode.sv
module mmu_win_decode
  import mmu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hD500,
  parameter int WIN_SLOTS = 12,
  parameter logic [ADDR_W-1:0] MIR_BASE = 16'hFF00,
  parameter int MIR_SLOTS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              io_off,
  input  logic              compat,
  output logic              win_hit,
  output logic              mir_hit,
  output logic [SLOT_W-1:0] slot
);
  logic [ADDR_W-1:0] woff, moff;

  always_comb begin
    woff    = addr - WIN_BASE;
    moff    = addr - MIR_BASE;
    win_hit = !compat && !io_off && (addr >= WIN_BASE) && (woff < ADDR_W'(WIN_SLOTS));
    mir_hit = !compat && (addr >= MIR_BASE) && (moff < ADDR_W'(MIR_SLOTS));
    slot    = win_hit ? woff[SLOT_W-1:0] : moff[SLOT_W-1:0];
  end

  a_r3_io_closed: assert property (@(posedge clk) disable iff (!rst_n)
    io_off |-> !win_hit);
  a_r2_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    compat |-> !(win_hit || mir_hit));
endmodule

// File: rtl/mmu_reg_file.sv
module mmu_reg_file
  import mmu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         win_hit,
  input  logic                         mir_hit,
  input  logic [SLOT_W-1:0]            slot,
  input  logic [DATA_W-1:0]            wdata,
  output logic [NSLOT-1:0][DATA_W-1:0] file,
  output logic                         cpu_sel_q,
  output logic                         fsdir_q
);
  localparam logic [DATA_W-1:0] MASK7   = DATA_W'(8'h7F);
  localparam logic [DATA_W-1:0] RAMMASK = DATA_W'(8'h4F);
  localparam logic [DATA_W-1:0] P1_INIT = DATA_W'(1);

  logic stage0, stage1;
  logic win_we, mir_we, mode_we;
  logic [DATA_W-1:0] preset_sel;

  assign win_we     = wr_en && win_hit;
  assign mir_we     = wr_en && mir_hit;
  assign mode_we    = win_we && (slot == SL_MODE);
  assign preset_sel = file[slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      file         <= '0;
      file[SL_P1L] <= P1_INIT;
      stage0       <= 1'b0;
      stage1       <= 1'b0;
    end else if (win_we) begin
      if (slot == SL_CFG || (slot >= SL_PRE_LO && slot <= SL_PRE_HI))
        file[slot] <= wdata & MASK7;
      else if (slot == SL_RAM)
        file[slot] <= wdata & RAMMASK;
      else if (slot == SL_P0H)
        stage0 <= wdata[0];
      else if (slot == SL_P1H)
        stage1 <= wdata[0];
      else if (slot == SL_P0L) begin
        file[SL_P0L] <= wdata;
        file[SL_P0H] <= DATA_W'(stage0);
      end else if (slot == SL_P1L) begin
        file[SL_P1L] <= wdata;
        file[SL_P1H] <= DATA_W'(stage1);
      end else
        file[slot] <= wdata;
    end else if (mir_we) begin
      if (slot == SL_CFG) file[SL_CFG] <= wdata & MASK7;
      else                file[SL_CFG] <= preset_sel & MASK7;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_sel_q <= 1'b0;
      fsdir_q   <= 1'b0;
    end else if (mode_we) begin
      if (wdata[MODE_CPU_BIT] != file[SL_MODE][MODE_CPU_BIT]) cpu_sel_q <= wdata[MODE_CPU_BIT];
      if (wdata[MODE_FSD_BIT] != file[SL_MODE][MODE_FSD_BIT]) fsdir_q   <= wdata[MODE_FSD_BIT];
    end
  end

  a_r2_compat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    file[SL_MODE][MODE_COMPAT_BIT] |=> $stable(file));
  a_r8_high_deferred: assert property (@(posedge clk) disable iff (!rst_n)
    (win_we && slot == SL_P0H) |=> $stable(file[SL_P0H]));
  a_r9_preset_load: assert property (@(posedge clk) disable iff (!rst_n)
    (mir_we && slot != SL_CFG) |=> (file[SL_CFG] == ($past(preset_sel) & MASK7)));
  a_r10_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_we |=> ($stable(cpu_sel_q) && $stable(fsdir_q)));
  a_r10_flags_track: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> (cpu_sel_q == file[SL_MODE][MODE_CPU_BIT] && fsdir_q == file[SL_MODE][MODE_FSD_BIT]));
endmodule

// File: rtl/mmu_read_mux.sv
module mmu_read_mux
  import mmu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] VERSION = 8'h20
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NSLOT-1:0][DATA_W-1:0] file,
  input  logic                         win_hit,
  input  logic                         mir_hit,
  input  logic [SLOT_W-1:0]            slot,
  input  logic [DATA_W-1:0]            bus_in,
  input  logic                         cart_game,
  input  logic                         cart_exrom,
  input  logic                         width_sense,
  output logic [DATA_W-1:0]            rdata
);
  localparam logic [DATA_W-1:0] CFG_SET  = DATA_W'(8'h80);
  localparam logic [DATA_W-1:0] MODE_SET = DATA_W'(8'h06);

  logic [DATA_W-1:0] pin_mask;

  always_comb begin
    pin_mask    = '1;
    pin_mask[4] = cart_game;
    pin_mask[5] = cart_exrom;
    pin_mask[7] = width_sense;
    if (win_hit) begin
      if (slot == SL_CFG)       rdata = file[SL_CFG] | CFG_SET;
      else if (slot == SL_MODE) rdata = (file[SL_MODE] | MODE_SET) & pin_mask;
      else if (slot == SL_VER)  rdata = VERSION;
      else                      rdata = file[slot];
    end else if (mir_hit) begin
      if (slot == SL_CFG) rdata = file[SL_CFG] | CFG_SET;
      else                rdata = file[slot];
    end else
      rdata = bus_in;
  end

  a_r7_version: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit && slot == SL_VER) |-> rdata == VERSION);
  a_r3_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_hit && !mir_hit) |-> rdata == bus_in);
  a_r4_cfg_msb: assert property (@(posedge clk) disable iff (!rst_n)
    ((win_hit || mir_hit) && slot == SL_CFG) |-> rdata[7]);
endmodule

// File: rtl/mmu_bank_regs.sv
module mmu_bank_regs
  import mmu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hD500,
  parameter logic [ADDR_W-1:0] MIR_BASE = 16'hFF00,
  parameter logic [DATA_W-1:0] VERSION  = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] bus_in,
  input  logic              cart_game,
  input  logic              cart_exrom,
  input  logic              width_sense,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] cfg_o,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] ramcfg_o,
  output logic [DATA_W:0]   page0_o,
  output logic [DATA_W:0]   page1_o,
  output logic              cpu_sel,
  output logic              fsdir
);
  localparam int WIN_SLOTS = int'(SL_VER) + 1;
  localparam int MIR_SLOTS = int'(SL_PRE_HI) + 1;

  logic [NSLOT-1:0][DATA_W-1:0] file;
  logic win_hit, mir_hit;
  logic [SLOT_W-1:0] slot;

  mmu_win_decode #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_SLOTS(WIN_SLOTS),
    .MIR_BASE(MIR_BASE), .MIR_SLOTS(MIR_SLOTS)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .io_off(file[SL_CFG][CFG_IO_BIT]),
    .compat(file[SL_MODE][MODE_COMPAT_BIT]),
    .win_hit(win_hit), .mir_hit(mir_hit), .slot(slot)
  );

  mmu_reg_file #(.DATA_W(DATA_W)) u_file (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .win_hit(win_hit),
    .mir_hit(mir_hit), .slot(slot), .wdata(wdata), .file(file),
    .cpu_sel_q(cpu_sel), .fsdir_q(fsdir)
  );

  mmu_read_mux #(.DATA_W(DATA_W), .VERSION(VERSION)) u_rd (
    .clk(clk), .rst_n(rst_n), .file(file), .win_hit(win_hit),
    .mir_hit(mir_hit), .slot(slot), .bus_in(bus_in),
    .cart_game(cart_game), .cart_exrom(cart_exrom),
    .width_sense(width_sense), .rdata(rdata)
  );

  assign cfg_o    = file[SL_CFG];
  assign mode_o   = file[SL_MODE];
  assign ramcfg_o = file[SL_RAM];
  assign page0_o  = {file[SL_P0H][0], file[SL_P0L]};
  assign page1_o  = {file[SL_P1H][0], file[SL_P1L]};
endmodule

// File: tb/sim_mmu_bank_regs.sv
module sim_mmu_bank_regs;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic wr_en = 1'b0;
  logic [7:0] wdata = '0, bus_in = '0;
  logic cart_game = 1'b1, cart_exrom = 1'b1, width_sense = 1'b1;
  logic [7:0] rdata, cfg_o, mode_o, ramcfg_o;
  logic [8:0] page0_o, page1_o;
  logic cpu_sel, fsdir;

  int n_run = 0, n_fail = 0;
  logic [7:0] m [16];
  logic st0, st1;

  always #(CLK_NS/2) clk = ~clk;

  mmu_bank_regs u0 (.*);

  initial begin
    #(CLK_NS * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m[i] = 8'h00;
    m[9] = 8'h01; st0 = 1'b0; st1 = 1'b0;
  endtask

  function automatic logic [7:0] exp_rd(input logic [15:0] a, input logic [7:0] b);
    logic [3:0] s;
    if (m[5][6]) return b;
    if (!m[0][0] && a >= 16'hD500 && a <= 16'hD50B) begin
      s = a[3:0];
      case (s)
        4'd0: return m[0] | 8'h80;
        4'd5: return (m[5] | 8'h06) & {width_sense, 1'b1, cart_exrom, cart_game, 4'hF};
        4'd11: return 8'h20;
        default: return m[s];
      endcase
    end
    if (a >= 16'hFF00 && a <= 16'hFF04) begin
      s = a[3:0];
      return (s == 0) ? (m[0] | 8'h80) : m[s];
    end
    return b;
  endfunction

  task automatic model_wr(input logic [15:0] a, input logic [7:0] d);
    logic [3:0] s;
    if (m[5][6]) return;
    s = a[3:0];
    if (!m[0][0] && a >= 16'hD500 && a <= 16'hD50B) begin
      case (s)
        4'd0, 4'd1, 4'd2, 4'd3, 4'd4: m[s] = d & 8'h7F;
        4'd6: m[s] = d & 8'h4F;
        4'd8: st0 = d[0];
        4'd10: st1 = d[0];
        4'd7: begin m[7] = d; m[8] = {7'd0, st0}; end
        4'd9: begin m[9] = d; m[10] = {7'd0, st1}; end
        default: m[s] = d;
      endcase
    end else if (a >= 16'hFF00 && a <= 16'hFF04) begin
      m[0] = (s == 0) ? (d & 8'h7F) : (m[s] & 8'h7F);
    end
  endtask

  task automatic check_exports(input string req);
    chk(req, {8'd0, cfg_o}, {8'd0, m[0]});
    chk(req, {8'd0, mode_o}, {8'd0, m[5]});
    chk(req, {8'd0, ramcfg_o}, {8'd0, m[6]});
    chk(req, {7'd0, page0_o}, {7'd0, m[8][0], m[7]});
    chk(req, {7'd0, page1_o}, {7'd0, m[10][0], m[9]});
    chk(req, {14'd0, cpu_sel, fsdir}, {14'd0, m[5][0], m[5][3]});
  endtask

  task automatic do_wr(input string req, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    model_wr(a, d);
    @(negedge clk);
    wr_en = 1'b0;
    check_exports(req);
  endtask

  task automatic do_rd(input string req, input logic [15:0] a, input logic [7:0] b);
    @(negedge clk);
    addr = a; bus_in = b; wr_en = 1'b0;
    #1;
    chk(req, {8'd0, rdata}, {8'd0, exp_rd(a, b)});
  endtask

  initial begin
    logic [15:0] a;
    logic [7:0] d;
    int unsigned pick;
    void'($urandom(32'h5EED_1234));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_exports("R1");
    chk("R1", {7'd0, page1_o}, 16'h0001);
    do_rd("R1", 16'hD509, 8'h5A);
    do_rd("R1", 16'hD501, 8'h5A);
    // R4 config mask and readback
    do_wr("R4", 16'hD500, 8'hFE);
    chk("R4", {8'd0, cfg_o}, 16'h007E);
    do_rd("R4", 16'hD500, 8'h00);
    do_rd("R4", 16'hFF00, 8'h00);
    do_wr("R4", 16'hFF00, 8'h00);
    // R5 masks
    do_wr("R5", 16'hD501, 8'hFF);
    do_rd("R5", 16'hD501, 8'h00);
    chk("R5", {8'd0, rdata}, 16'h007F);
    do_wr("R5", 16'hD506, 8'hFF);
    chk("R5", {8'd0, ramcfg_o}, 16'h004F);
    // R6 mode readback with pins
    cart_game = 1'b1; cart_exrom = 1'b0; width_sense = 1'b1;
    do_wr("R6", 16'hD505, 8'hB0);
    do_rd("R6", 16'hD505, 8'h00);
    chk("R6", {8'd0, rdata}, 16'h0096);
    cart_game = 1'b0; cart_exrom = 1'b1; width_sense = 1'b0;
    do_rd("R6", 16'hD505, 8'h00);
    chk("R6", {8'd0, rdata}, 16'h0026);
    cart_game = 1'b1; width_sense = 1'b1;
    // R7 version
    do_wr("R7", 16'hD50B, 8'h55);
    do_rd("R7", 16'hD50B, 8'h00);
    chk("R7", {8'd0, rdata}, 16'h0020);
    // R8 staged page pointer high bytes
    do_wr("R8", 16'hD508, 8'h03);
    chk("R8", {7'd0, page0_o}, 16'h0000);
    do_rd("R8", 16'hD508, 8'hAA);
    do_wr("R8", 16'hD507, 8'h12);
    chk("R8", {7'd0, page0_o}, 16'h0112);
    do_wr("R8", 16'hD50A, 8'hFF);
    do_wr("R8", 16'hD509, 8'h40);
    chk("R8", {7'd0, page1_o}, 16'h0140);
    // R9 preset load ignores data
    do_wr("R9", 16'hD502, 8'h3C);
    do_wr("R9", 16'hFF02, 8'hAA);
    chk("R9", {8'd0, cfg_o}, 16'h003C);
    do_rd("R9", 16'hFF00, 8'h00);
    chk("R9", {8'd0, rdata}, 16'h00BC);
    do_wr("R9", 16'hFF00, 8'h00);
    // R3 window closed by I/O bit, mirror stays
    do_wr("R3", 16'hFF00, 8'h01);
    do_wr("R3", 16'hD501, 8'h11);
    do_rd("R3", 16'hFF01, 8'h00);
    chk("R3", {8'd0, rdata}, 16'h007F);
    do_rd("R3", 16'hD501, 8'hC3);
    chk("R3", {8'd0, rdata}, 16'h00C3);
    do_rd("R3", 16'h1234, 8'h99);
    do_rd("R3", 16'hD50C, 8'h77);
    do_wr("R3", 16'hFF00, 8'h00);
    // R10 registered flags
    do_wr("R10", 16'hD505, 8'h09);
    chk("R10", {14'd0, cpu_sel, fsdir}, 16'h0003);
    do_wr("R10", 16'hD505, 8'h08);
    chk("R10", {14'd0, cpu_sel, fsdir}, 16'h0001);
    // R11 random mix
    for (int i = 0; i < 3000; i++) begin
      pick = $urandom_range(0, 9);
      d = 8'($urandom);
      if (pick < 4)      a = 16'hD500 + 16'($urandom_range(0, 11));
      else if (pick < 7) a = 16'hFF00 + 16'($urandom_range(0, 4));
      else if (pick < 8) a = 16'hD50C + 16'($urandom_range(0, 3));
      else               a = 16'($urandom);
      if (a == 16'hD505) d[6] = 1'b0;
      cart_game = 1'($urandom); cart_exrom = 1'($urandom); width_sense = 1'($urandom);
      if ($urandom_range(0, 1) == 0) do_wr("R11", a, d);
      else do_rd("R11", a, d);
    end
    // R2 compatibility freeze
    do_wr("R2", 16'hFF00, 8'h00);
    do_wr("R2", 16'hD505, 8'h40);
    do_rd("R2", 16'hD505, 8'h3E);
    chk("R2", {8'd0, rdata}, 16'h003E);
    do_rd("R2", 16'hFF00, 8'h61);
    do_wr("R2", 16'hFF00, 8'h22);
    chk("R2", {8'd0, cfg_o}, 16'h0000);
    do_wr("R2", 16'hD505, 8'h00);
    chk("R2", {8'd0, mode_o}, 16'h0040);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule